// File: doc/BRIEF.md
# Misaligned Access Exception Sequencer

This block runs the exception entry that follows a misaligned memory access in a processor core with a 16-bit data bus. When the core reports a word or long access whose address has bit 0 set, the sequencer takes over the memory port. It chooses the supervisor stack, writing a seven-word exception frame below it. The frame holds the return PC, the old status register, a blank instruction-register slot, the faulting address and a packed access-status word. The sequencer then reads the handler address from the vector table, holds off for a fixed penalty, and hands the core its new stack pointers, status register and program counter.

The core presents one access per cycle on the `acc_*` inputs, together with its current state. If the core is in user mode, the two stack pointers trade places before anything is pushed. Each bus request stays up, with address and data unchanged, until the memory acknowledges it. The results appear on the outputs in the same cycle as the one-cycle `done` pulse, and they hold until the next fault completes.

Top module: `addr_fault_seq`

## Requirements
- R1: A fault starts only when `acc_valid`, `acc_wide` and `acc_addr[0]` are all 1 while `busy` is 0. A byte access, an even address, or any access made while `busy` is 1 issues no bus request and does not change the frame being built.
- R2: The frame base is `a7_in` when `sr_in[13]` is 1, and `shadow_in` when it is 0. At completion, `shadow_out` equals `shadow_in` in the first case and `a7_in` in the second.
- R3: With base B, the writes are issued in this order: B-2 gets PC[15:0], B-4 gets PC[31:16], B-6 gets the status register, B-8 gets 0, B-10 gets the fault address [15:0], B-12 gets the fault address [31:16], and B-14 gets the access-status word. PC here is `prefetch_pc`. Every request address is even.
- R4: The access-status word is zero except in these bits: bit 4 is 1 for a read, bit 2 is the old `sr_in[13]`, bit 1 is 1 for an instruction fetch, and bit 0 is 1 for a data access. This gives 0x12 for a fetch read, 0x11 for a data read and 0x01 for a data write, plus 0x04 when the core was in supervisor mode.
- R5: The status register written to the frame is `sr_in` unchanged. `sr_out` equals `sr_in` with bit 13 set.
- R6: After the writes come two reads: 0x00C, then 0x00E. `pc_out` is {first read word, second read word}.
- R7: `sp_out` equals B-14.
- R8: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged into the next cycle.
- R9: `done` goes high for exactly one cycle, 18 clock edges after the edge that accepts the second vector read. The outputs are valid in that cycle.
- R10: After reset, `mem_req`, `busy` and `done` are 0, and `sp_out`, `shadow_out`, `sr_out` and `pc_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | The core presents an access this cycle |
| acc_wide | input | 1 | 1 for a word or long access, 0 for a byte access |
| acc_addr | input | 32 | Access address |
| acc_fetch | input | 1 | 1 for an instruction fetch |
| acc_write | input | 1 | 1 for a write |
| sr_in | input | 16 | Current status register, with bit 13 as the supervisor bit |
| a7_in | input | 32 | Active stack pointer |
| shadow_in | input | 32 | Inactive stack pointer |
| prefetch_pc | input | 32 | Last prefetch address, used as the return PC |
| mem_req | output | 1 | Bus request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Bus byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid while `mem_ack` is 1 |
| mem_ack | input | 1 | Acknowledge, which completes the current request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 32 | New active (supervisor) stack pointer |
| shadow_out | output | 32 | New inactive stack pointer |
| sr_out | output | 16 | New status register |
| pc_out | output | 32 | Handler address |

## Verification
The hardest situation to reach from the ports is a request held under back-pressure. Another is a second misaligned access that arrives while a frame is half written. The memory responder in the bench takes a per-vector latency of zero to three cycles. While a request waits, it compares the address, direction and data against their first-seen values. One directed run pulses a second odd word access three cycles into a sequence, then confirms that the nine transfers and the outputs still belong to the first fault. Vectors cover both privilege levels and all three fault kinds, so the frame base, the swapped stack and every status-word encoding are each seen.

// File: rtl/addr_fault_seq.sv
module addr_fault_seq #(
  parameter int          PENALTY  = 18,
  parameter logic [31:0] VEC_ADDR = 32'h0000_000C,
  parameter int          SBIT     = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_wide,
  input  logic [31:0] acc_addr,
  input  logic        acc_fetch,
  input  logic        acc_write,
  input  logic [15:0] sr_in,
  input  logic [31:0] a7_in,
  input  logic [31:0] shadow_in,
  input  logic [31:0] prefetch_pc,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_ack,
  output logic        busy,
  output logic        done,
  output logic [31:0] sp_out,
  output logic [31:0] shadow_out,
  output logic [15:0] sr_out,
  output logic [31:0] pc_out
);
  localparam int          CW          = (PENALTY > 1) ? $clog2(PENALTY) : 1;
  localparam logic [3:0]  VEC_HI_STEP = 4'd7;
  localparam logic [3:0]  LAST_STEP   = 4'd8;
  localparam logic [31:0] FRAME_BYTES = 32'd14;

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_WAIT} st_t;

  st_t         st;
  logic [3:0]  step;
  logic [CW-1:0] cnt;
  logic [31:0] base_q, other_q, pc_q, fa_q, vec_q;
  logic [15:0] sr_q;
  logic        fetch_q, wr_q;
  logic        start;
  logic [15:0] stat_word;

  assign start     = (st == S_IDLE) && acc_valid && acc_wide && acc_addr[0];
  assign stat_word = {11'd0, ~wr_q, 1'b0, sr_q[SBIT], fetch_q, ~fetch_q};
  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_BUS);

  always_comb begin
    mem_we    = 1'b1;
    mem_addr  = base_q;
    mem_wdata = 16'd0;
    case (step)
      4'd0: begin mem_addr = base_q - 32'd2;  mem_wdata = pc_q[15:0];  end
      4'd1: begin mem_addr = base_q - 32'd4;  mem_wdata = pc_q[31:16]; end
      4'd2: begin mem_addr = base_q - 32'd6;  mem_wdata = sr_q;        end
      4'd3: begin mem_addr = base_q - 32'd8;  mem_wdata = 16'd0;       end
      4'd4: begin mem_addr = base_q - 32'd10; mem_wdata = fa_q[15:0];  end
      4'd5: begin mem_addr = base_q - 32'd12; mem_wdata = fa_q[31:16]; end
      4'd6: begin mem_addr = base_q - 32'd14; mem_wdata = stat_word;   end
      4'd7: begin mem_we = 1'b0; mem_addr = VEC_ADDR;                  end
      4'd8: begin mem_we = 1'b0; mem_addr = VEC_ADDR + 32'd2;          end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      step       <= 4'd0;
      cnt        <= '0;
      base_q     <= '0;
      other_q    <= '0;
      pc_q       <= '0;
      fa_q       <= '0;
      vec_q      <= '0;
      sr_q       <= '0;
      fetch_q    <= 1'b0;
      wr_q       <= 1'b0;
      done       <= 1'b0;
      sp_out     <= '0;
      shadow_out <= '0;
      sr_out     <= '0;
      pc_out     <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st      <= S_BUS;
          step    <= 4'd0;
          base_q  <= sr_in[SBIT] ? a7_in : shadow_in;
          other_q <= sr_in[SBIT] ? shadow_in : a7_in;
          sr_q    <= sr_in;
          pc_q    <= prefetch_pc;
          fa_q    <= acc_addr;
          fetch_q <= acc_fetch;
          wr_q    <= acc_write;
        end
        S_BUS: if (mem_ack) begin
          if (step == VEC_HI_STEP) vec_q[31:16] <= mem_rdata;
          if (step == LAST_STEP) begin
            vec_q[15:0] <= mem_rdata;
            st          <= S_WAIT;
            cnt         <= CW'(PENALTY - 1);
          end else begin
            step <= step + 4'd1;
          end
        end
        S_WAIT: if (cnt == '0) begin
          st         <= S_IDLE;
          done       <= 1'b1;
          sp_out     <= base_q - FRAME_BYTES;
          shadow_out <= other_q;
          sr_out     <= sr_q | (16'd1 << SBIT);
          pc_out     <= vec_q;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R3
  even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);

  // R6
  vec_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr == VEC_ADDR || mem_addr == VEC_ADDR + 32'd2));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  sr_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sr_out[SBIT]);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(acc_valid && acc_wide && acc_addr[0])) |=> (!busy && !mem_req));
endmodule

// File: tb/addr_fault_seq_tb_top.sv
module addr_fault_seq_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        acc_valid, acc_wide, acc_fetch, acc_write;
  logic [31:0] acc_addr, a7_in, shadow_in, prefetch_pc;
  logic [15:0] sr_in;
  logic        mem_req, mem_we, mem_ack, busy, done;
  logic [31:0] mem_addr, sp_out, shadow_out, pc_out;
  logic [15:0] mem_wdata, mem_rdata, sr_out;

  addr_fault_seq dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_wide(acc_wide),
    .acc_addr(acc_addr), .acc_fetch(acc_fetch), .acc_write(acc_write),
    .sr_in(sr_in), .a7_in(a7_in), .shadow_in(shadow_in), .prefetch_pc(prefetch_pc),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy), .done(done),
    .sp_out(sp_out), .shadow_out(shadow_out), .sr_out(sr_out), .pc_out(pc_out)
  );

  localparam int PEN = 18;

  typedef struct packed {
    logic        wide;
    logic [31:0] addr;
    logic        fetch;
    logic        wr;
    logic [15:0] sr;
    logic [31:0] a7;
    logic [31:0] sh;
    logic [31:0] pc;
    logic [31:0] vec;
    logic [15:0] stw;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 32'h0001_2345, 1'b1, 1'b0, 16'h0700, 32'h0000_F000, 32'h00FF_FE00, 32'h0000_1236, 32'h0000_0400, 16'h0012, 2'd0},
    '{1'b1, 32'h00FF_0011, 1'b0, 1'b0, 16'h2704, 32'h00FF_8000, 32'h0000_1000, 32'h00AB_CDE0, 32'h1234_5678, 16'h0015, 2'd1},
    '{1'b1, 32'hDEAD_BEEF, 1'b0, 1'b1, 16'h001F, 32'h0010_0000, 32'h0020_0000, 32'h0000_4000, 32'h00C0_FFEE, 16'h0001, 2'd2},
    '{1'b1, 32'h0000_0001, 1'b0, 1'b1, 16'hA700, 32'h0000_3000, 32'h0000_9000, 32'h0000_0100, 32'h0000_8000, 16'h0005, 2'd3},
    '{1'b1, 32'h0040_0003, 1'b1, 1'b0, 16'h2000, 32'h0000_0800, 32'h0000_0400, 32'h0040_0004, 32'h8765_4321, 16'h0016, 2'd1},
    '{1'b0, 32'h0000_0101, 1'b0, 1'b0, 16'h2700, 32'h0000_2000, 32'h0000_4000, 32'h0000_0200, 32'h0000_0000, 16'h0000, 2'd0},
    '{1'b1, 32'h0000_0100, 1'b0, 1'b1, 16'h0000, 32'h0000_2000, 32'h0000_4000, 32'h0000_0200, 32'h0000_0000, 16'h0000, 2'd0}
  };

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory responder
  logic [31:0] t_addr [16];
  logic        t_we   [16];
  logic [15:0] t_data [16];
  int          ntx, last_cyc, lat, wcnt, stab_err;
  logic        tb_clr, p_wait, p_we;
  logic [31:0] p_addr, vec_val;
  logic [15:0] p_data;

  assign mem_rdata = (mem_addr == 32'h0000_000C) ? vec_val[31:16] : vec_val[15:0];

  initial begin
    mem_ack = 1'b0; ntx = 0; wcnt = 0; stab_err = 0; p_wait = 1'b0; last_cyc = 0;
    p_we = 1'b0; p_addr = '0; p_data = '0;
    forever begin
      @(negedge clk);
      if (tb_clr) begin
        ntx = 0; stab_err = 0; wcnt = 0; p_wait = 1'b0; mem_ack = 1'b0;
      end else if (!mem_req) begin
        mem_ack = 1'b0; wcnt = 0; p_wait = 1'b0;
      end else if (mem_ack && lat != 0) begin
        mem_ack = 1'b0; wcnt = 0; p_wait = 1'b0;
      end else begin
        if (p_wait && (mem_addr != p_addr || mem_we != p_we || mem_wdata != p_data))
          stab_err = stab_err + 1;
        if (wcnt >= lat) begin
          if (ntx < 16) begin
            t_addr[ntx] = mem_addr; t_we[ntx] = mem_we; t_data[ntx] = mem_wdata;
          end
          ntx = ntx + 1;
          last_cyc = cyc;
          mem_ack = 1'b1; wcnt = 0; p_wait = 1'b0;
        end else begin
          if (!p_wait) begin p_addr = mem_addr; p_we = mem_we; p_data = mem_wdata; end
          wcnt = wcnt + 1; p_wait = 1'b1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int i, input bit intrude);
    vec_t v = TBL[i];
    logic [31:0] b;
    logic [31:0] ea [9];
    logic [15:0] ed [9];
    string       tg [9];
    int t;
    @(posedge clk); #2;
    tb_clr = 1'b1; lat = int'(v.lat); vec_val = v.vec;
    @(posedge clk); #2;
    tb_clr = 1'b0;
    acc_valid = 1'b1; acc_wide = v.wide; acc_addr = v.addr; acc_fetch = v.fetch;
    acc_write = v.wr; sr_in = v.sr; a7_in = v.a7; shadow_in = v.sh; prefetch_pc = v.pc;
    @(posedge clk); #2;
    acc_valid = 1'b0;
    if (intrude) begin
      repeat (3) @(posedge clk);
      #2;
      acc_valid = 1'b1; acc_wide = 1'b1; acc_addr = 32'h0000_0777; acc_fetch = 1'b0;
      acc_write = 1'b1; sr_in = 16'h0000; a7_in = 32'h0000_5550; prefetch_pc = 32'h0000_9990;
      @(posedge clk); #2;
      acc_valid = 1'b0;
    end
    if (!(v.wide && v.addr[0])) begin
      repeat (30) @(negedge clk);
      chk("R1 no request", 32'(ntx), 32'd0);
      chk("R1 idle", 32'(busy), 32'd0);
      return;
    end
    b = v.sr[13] ? v.a7 : v.sh;
    ea[0] = b - 2;  ed[0] = v.pc[15:0];    tg[0] = "R3 pc low";
    ea[1] = b - 4;  ed[1] = v.pc[31:16];   tg[1] = "R3 pc high";
    ea[2] = b - 6;  ed[2] = v.sr;          tg[2] = "R5 pushed sr";
    ea[3] = b - 8;  ed[3] = 16'h0000;      tg[3] = "R3 ir slot";
    ea[4] = b - 10; ed[4] = v.addr[15:0];  tg[4] = "R3 fault low";
    ea[5] = b - 12; ed[5] = v.addr[31:16]; tg[5] = "R3 fault high";
    ea[6] = b - 14; ed[6] = v.stw;         tg[6] = "R4 status word";
    ea[7] = 32'h0000_000C; ed[7] = 16'h0; tg[7] = "R6 vec hi";
    ea[8] = 32'h0000_000E; ed[8] = 16'h0; tg[8] = "R6 vec lo";
    t = 0;
    while (!done && t < 400) begin @(negedge clk); t++; end
    chk("R9 done seen", 32'(done), 32'd1);
    chk("R9 penalty", 32'(cyc - last_cyc), 32'(PEN + 1));
    chk("R3 transfer count", 32'(ntx), 32'd9);
    for (int k = 0; k < 9; k++) begin
      chk(k == 0 ? "R2 frame base" : "R3 address", t_addr[k], ea[k]);
      chk(k < 7 ? "R3 direction" : "R6 direction", 32'(t_we[k]), k < 7 ? 32'd1 : 32'd0);
      if (k < 7) chk(tg[k], 32'(t_data[k]), 32'(ed[k]));
    end
    chk("R6 pc_out", pc_out, v.vec);
    chk("R7 sp_out", sp_out, b - 14);
    chk("R2 shadow_out", shadow_out, v.sr[13] ? v.sh : v.a7);
    chk("R5 sr_out", 32'(sr_out), 32'(v.sr | 16'h2000));
    chk("R8 held request", 32'(stab_err), 32'd0);
    @(negedge clk);
    chk("R9 one cycle", 32'(done), 32'd0);
    if (intrude) begin
      repeat (10) @(negedge clk);
      chk("R1 no restart", 32'(busy), 32'd0);
      chk("R1 no extra transfers", 32'(ntx), 32'd9);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tb_clr = 1'b1; lat = 0; vec_val = '0;
    rst_n = 1'b0; acc_valid = 1'b0; acc_wide = 1'b0; acc_addr = '0; acc_fetch = 1'b0;
    acc_write = 1'b0; sr_in = '0; a7_in = '0; shadow_in = '0; prefetch_pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 req", 32'(mem_req), 32'd0);
    chk("R10 busy", 32'(busy), 32'd0);
    chk("R10 done", 32'(done), 32'd0);
    chk("R10 pc_out", pc_out, 32'd0);
    chk("R10 sp_out", sp_out, 32'd0);
    chk("R10 shadow_out", shadow_out, 32'd0);
    chk("R10 sr_out", 32'(sr_out), 32'd0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(i, 1'b0);
    run_vec(0, 1'b1);
    run_vec(3, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule